// File: doc/BRIEF.md
# Latched Event Status Register

This block keeps two sets of sticky event flags and lets a host read and clear them through a small command interface. The first set is an 8-bit overload register. Three level-type condition inputs feed it: bias overload, output overload, and combined transimpedance-stage overload. A flag is latched only when its condition newly appears. If a condition is still present after a read, the flag stays clear until that condition drops and then comes back. The second set is a 4-bit clock event register. It is fed by single-cycle pulses that report the reference clock stopping, arriving, losing lock and gaining lock.

An 8-bit enable mask is applied bit by bit to the overload register. When any masked bit is set, one summary output is raised. Each read command is decoded in one cycle, and its data comes back registered on the next cycle. A read that clears flags returns the value the flags held before the clear. A separate strobe input wipes both event registers at once.

The command port is served by an access state machine with two states. In `ST_IDLE` no response is pending. In `ST_RESP` a read response is on the output. The machine has three transitions. ISSUE goes from `ST_IDLE` to `ST_RESP` when a read command arrives. CHAIN stays in `ST_RESP` when a read command arrives back to back. DONE returns from `ST_RESP` to `ST_IDLE` when no read command arrives.

Top module: `evt_status_regs`

## Requirements
- R1: After reset, both event registers, the enable mask, `rd_valid_o`, `rd_data_o` and `summary_o` are all 0.
- R2: Overload flags are mapped as follows: bit 0 is the bias condition (`ovld_cond_i[0]`), bit 1 is the output condition (`ovld_cond_i[1]`), bit 2 is the combined condition (`ovld_cond_i[2]`), and bits 7..3 always read 0. A condition that rises before clock edge n shows up as a set flag after edge n+1.
- R3: A flag is set only on a rising edge of its condition. After a clear, a condition that stays high leaves the flag at 0 until the condition falls and rises again.
- R4: Opcode 0 (full overload read) places the overload register on `rd_data_o` with `rd_valid_o`=1 in the cycle after the command, and it clears every overload flag.
- R5: Opcode 1 (live read) returns the registered condition levels in bits 2..0 and does not change any latched flag.
- R6: Opcode 2 writes `cmd_wdata_i` into the enable mask and gives no response. Opcode 3 reads the mask back.
- R7: `summary_o` is 1 exactly when the bitwise AND of the enable mask and the overload register is nonzero.
- R8: Clock event flags are mapped as follows: bit 0 is clock stopped, bit 1 is clock arrived, bit 2 is unlock and bit 3 is lock. A pulse on `clk_evt_i[k]` sets flag k at the next edge, and the flag holds until it is cleared. Opcode 4 returns the register with bits 7..4 at 0 and clears all four flags.
- R9: Opcode 5 with index i (0..3) returns flag i in `rd_data_o[0]` with all other bits 0, and it clears only flag i. An index of 4..7 returns 0 and clears nothing.
- R10: A one-cycle pulse on `clr_all_i` clears both event registers.
- R11: When a set (a condition edge or an event pulse) and a clear of the same flag meet in one cycle, the flag ends up set. A read in that cycle returns the value from before the clear.
- R12: Opcodes 6 and 7 produce no response and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovld_cond_i | input | 3 | Overload condition levels (bias, output, combined) |
| clk_evt_i | input | 4 | Clock event pulses (stop, arrive, unlock, lock) |
| clr_all_i | input | 1 | Clears both event registers |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode |
| cmd_idx_i | input | 3 | Bit index for single-bit read |
| cmd_wdata_i | input | 8 | Enable mask write data |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 8 | Read response data |
| summary_o | output | 1 | Masked overload summary |

## Verification
The hardest case to produce from the ports is a set and a clear landing on the same flag in the same cycle. This matters most for overload flags, because the internal rising-edge pulse lags the input by one register stage. To reach that cycle, the bench raises a condition, waits exactly one clock, and then issues the full read. That read must return 0 while the flag survives. For clock events, the bench drives a pulse in the same cycle as a read, and also in the same cycle as the clear-all strobe. Persistence after a clear is shown by reading twice while the condition stays high, then toggling it.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_OVLD_RD    = 3'd0,
        OP_LIVE_RD    = 3'd1,
        OP_ENA_WR     = 3'd2,
        OP_ENA_RD     = 3'd3,
        OP_CLK_RD     = 3'd4,
        OP_CLK_BIT_RD = 3'd5,
        OP_RSV6       = 3'd6,
        OP_RSV7       = 3'd7
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_st_e;

endpackage

// File: rtl/evt_rise_detect.sv
module evt_rise_detect #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] level_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            prev_q  <= '0;
        end else begin
            level_q <= level_i;
            prev_q  <= level_q;
        end
    end

    assign level_o = level_q;
    assign rise_o  = level_q & ~prev_q;

    // R3: a rise pulse never lasts two cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);

    logic [W-1:0] flag_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[b] <= 1'b0;
            end else if (set_i[b]) begin
                flag_q[b] <= 1'b1;
            end else if (clr_i[b]) begin
                flag_q[b] <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;

    // R8: a flag with no set and no clear keeps its value
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i | clr_i) == '0) |=> $stable(flag_o));

endmodule

// File: rtl/evt_access_fsm.sv
module evt_access_fsm
    import evt_status_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVLD_W = 8,
    parameter int CLK_W  = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [OP_W-1:0]   cmd_op_i,
    input  logic [IDX_W-1:0]  cmd_idx_i,
    input  logic [OVLD_W-1:0] ovld_flags_i,
    input  logic [OVLD_W-1:0] live_i,
    input  logic [OVLD_W-1:0] ena_i,
    input  logic [CLK_W-1:0]  clk_flags_i,
    output logic              ovld_clr_o,
    output logic [CLK_W-1:0]  clk_clr_o,
    output logic              ena_we_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);

    acc_st_e           state_q, state_n;
    op_e               op;
    logic              is_read;
    logic [DATA_W-1:0] data_n;
    logic [DATA_W-1:0] rd_data_q;

    assign op = op_e'(cmd_op_i);

    always_comb begin
        is_read    = 1'b0;
        data_n     = '0;
        ovld_clr_o = 1'b0;
        clk_clr_o  = '0;
        ena_we_o   = 1'b0;
        if (cmd_valid_i) begin
            unique case (op)
                OP_OVLD_RD: begin
                    is_read    = 1'b1;
                    data_n     = DATA_W'(ovld_flags_i);
                    ovld_clr_o = 1'b1;
                end
                OP_LIVE_RD: begin
                    is_read = 1'b1;
                    data_n  = DATA_W'(live_i);
                end
                OP_ENA_WR: begin
                    ena_we_o = 1'b1;
                end
                OP_ENA_RD: begin
                    is_read = 1'b1;
                    data_n  = DATA_W'(ena_i);
                end
                OP_CLK_RD: begin
                    is_read   = 1'b1;
                    data_n    = DATA_W'(clk_flags_i);
                    clk_clr_o = '1;
                end
                OP_CLK_BIT_RD: begin
                    is_read = 1'b1;
                    for (int b = 0; b < CLK_W; b++) begin
                        if (cmd_idx_i == IDX_W'(b)) begin
                            data_n[0]    = clk_flags_i[b];
                            clk_clr_o[b] = 1'b1;
                        end
                    end
                end
                OP_RSV6, OP_RSV7: begin
                    is_read = 1'b0;
                end
            endcase
        end
    end

    // Next state: ISSUE, CHAIN, DONE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_n = is_read ? ST_RESP : ST_IDLE;
            ST_RESP: state_n = is_read ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (is_read) begin
            rd_data_q <= data_n;
        end
    end

    assign rd_valid_o = (state_q == ST_RESP);
    assign rd_data_o  = rd_data_q;

    // R4: a read command is answered in the next cycle
    a_r4_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (op == OP_OVLD_RD)) |=> rd_valid_o);

    // R12: reserved opcodes never raise a response
    a_r12_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (op == OP_RSV6 || op == OP_RSV7)) |=> !rd_valid_o);

    // R9: a single-bit read returns at most bit 0
    a_r9_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op == OP_CLK_BIT_RD) |=> (rd_data_o[DATA_W-1:1] == '0));

endmodule

// File: rtl/evt_status_regs.sv
module evt_status_regs
    import evt_status_pkg::*;
#(
    parameter int OVLD_USED = 3,
    parameter int OVLD_W    = 8,
    parameter int CLK_W     = 4,
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OVLD_USED-1:0] ovld_cond_i,
    input  logic [CLK_W-1:0]     clk_evt_i,
    input  logic                 clr_all_i,
    input  logic                 cmd_valid_i,
    input  logic [OP_W-1:0]      cmd_op_i,
    input  logic [IDX_W-1:0]     cmd_idx_i,
    input  logic [DATA_W-1:0]    cmd_wdata_i,
    output logic                 rd_valid_o,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 summary_o
);

    logic [OVLD_USED-1:0] ovld_level;
    logic [OVLD_USED-1:0] ovld_rise;
    logic [OVLD_USED-1:0] ovld_bank;
    logic [OVLD_W-1:0]    ovld_flags;
    logic [OVLD_W-1:0]    ovld_live;
    logic [CLK_W-1:0]     clk_flags;
    logic                 ovld_rd_clr;
    logic [CLK_W-1:0]     clk_rd_clr;
    logic                 ena_we;
    logic [OVLD_W-1:0]    ena_q;

    evt_rise_detect #(.W(OVLD_USED)) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (ovld_cond_i),
        .level_o (ovld_level),
        .rise_o  (ovld_rise)
    );

    evt_flag_bank #(.W(OVLD_USED)) u_ovld_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ovld_rise),
        .clr_i  ({OVLD_USED{ovld_rd_clr | clr_all_i}}),
        .flag_o (ovld_bank)
    );

    evt_flag_bank #(.W(CLK_W)) u_clk_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (clk_evt_i),
        .clr_i  (clk_rd_clr | {CLK_W{clr_all_i}}),
        .flag_o (clk_flags)
    );

    assign ovld_flags = OVLD_W'(ovld_bank);
    assign ovld_live  = OVLD_W'(ovld_level);

    evt_access_fsm #(
        .DATA_W (DATA_W),
        .OVLD_W (OVLD_W),
        .CLK_W  (CLK_W),
        .IDX_W  (IDX_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_op_i     (cmd_op_i),
        .cmd_idx_i    (cmd_idx_i),
        .ovld_flags_i (ovld_flags),
        .live_i       (ovld_live),
        .ena_i        (ena_q),
        .clk_flags_i  (clk_flags),
        .ovld_clr_o   (ovld_rd_clr),
        .clk_clr_o    (clk_rd_clr),
        .ena_we_o     (ena_we),
        .rd_valid_o   (rd_valid_o),
        .rd_data_o    (rd_data_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else if (ena_we) begin
            ena_q <= OVLD_W'(cmd_wdata_i);
        end
    end

    assign summary_o = |(ena_q & ovld_flags);

    // R4: a full overload read with no new edge empties the register
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op_e'(cmd_op_i) == OP_OVLD_RD && ovld_rise == '0)
        |=> (ovld_flags == '0));

    // R7: a zero mask keeps the summary low
    a_r7_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |-> !summary_o);

    // R8: upper bits of a clock register read are zero
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op_e'(cmd_op_i) == OP_CLK_RD)
        |=> (rd_data_o[DATA_W-1:CLK_W] == '0));

    // R10: clear strobe without new events empties the clock register
    a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all_i && clk_evt_i == '0) |=> (clk_flags == '0));

    // R11: an event pulse is never lost to a same-cycle clear
    a_r11_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (|clk_evt_i) |=> ((clk_flags & $past(clk_evt_i)) == $past(clk_evt_i)));

endmodule

// File: tb/evt_status_regs_tb.sv
module evt_status_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] ovld_cond;
    logic [3:0] clk_evt;
    logic       clr_all;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [2:0] cmd_idx;
    logic [7:0] cmd_wdata;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       summary;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    evt_status_regs dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovld_cond_i (ovld_cond),
        .clk_evt_i   (clk_evt),
        .clr_all_i   (clr_all),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .cmd_idx_i   (cmd_idx),
        .cmd_wdata_i (cmd_wdata),
        .rd_valid_o  (rd_valid),
        .rd_data_o   (rd_data),
        .summary_o   (summary)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [2:0] idx, input logic [7:0] wd);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_idx   = idx;
        cmd_wdata = wd;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] op, input logic [2:0] idx, output logic [7:0] d);
        cmd(op, idx, 8'h00);
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 summary", {7'd0, summary}, 8'h00);
        rd(3'd3, 3'd0, d); check("R1 enable", d, 8'h00);
        rd(3'd0, 3'd0, d); check("R1 overload", d, 8'h00);
        rd(3'd4, 3'd0, d); check("R1 clock", d, 8'h00);
    endtask

    task automatic t_ovld_basic();
        logic [7:0] d;
        ovld_cond = 3'b101;
        step(2);
        ovld_cond = 3'b000;
        rd(3'd0, 3'd0, d);
        check("R2 bits bias+combined", d, 8'h05);
        check("R4 rd_valid", {7'd0, rd_valid}, 8'h01);
        rd(3'd0, 3'd0, d);
        check("R4 cleared", d, 8'h00);
        ovld_cond = 3'b010;
        step(2);
        ovld_cond = 3'b000;
        rd(3'd0, 3'd0, d);
        check("R2 output bit", d, 8'h02);
        step(1);
        check("R4 rd_valid drops", {7'd0, rd_valid}, 8'h00);
    endtask

    task automatic t_persist();
        logic [7:0] d;
        ovld_cond = 3'b010;
        step(2);
        rd(3'd0, 3'd0, d); check("R3 first", d, 8'h02);
        step(3);
        rd(3'd0, 3'd0, d); check("R3 held stays clear", d, 8'h00);
        ovld_cond = 3'b000;
        step(2);
        ovld_cond = 3'b010;
        step(2);
        rd(3'd0, 3'd0, d); check("R3 re-rise", d, 8'h02);
        ovld_cond = 3'b000;
        step(2);
    endtask

    task automatic t_live();
        logic [7:0] d;
        ovld_cond = 3'b011;
        step(2);
        rd(3'd1, 3'd0, d); check("R5 live", d, 8'h03);
        rd(3'd1, 3'd0, d); check("R5 live again", d, 8'h03);
        rd(3'd0, 3'd0, d); check("R5 flags kept", d, 8'h03);
        ovld_cond = 3'b000;
        step(2);
        rd(3'd1, 3'd0, d); check("R5 live low", d, 8'h00);
    endtask

    task automatic t_enable();
        logic [7:0] d;
        cmd(3'd2, 3'd0, 8'hA5);
        check("R6 write no resp", {7'd0, rd_valid}, 8'h00);
        rd(3'd3, 3'd0, d); check("R6 readback", d, 8'hA5);
        cmd(3'd2, 3'd0, 8'h04);
        ovld_cond = 3'b100;
        step(2);
        ovld_cond = 3'b000;
        check("R7 summary on", {7'd0, summary}, 8'h01);
        cmd(3'd2, 3'd0, 8'h03);
        check("R7 summary masked", {7'd0, summary}, 8'h00);
        cmd(3'd2, 3'd0, 8'hF8);
        check("R7 upper mask", {7'd0, summary}, 8'h00);
        cmd(3'd2, 3'd0, 8'h04);
        check("R7 summary back", {7'd0, summary}, 8'h01);
        rd(3'd0, 3'd0, d);
        check("R7 summary after read", {7'd0, summary}, 8'h00);
        cmd(3'd2, 3'd0, 8'h00);
    endtask

    task automatic t_clk_events();
        logic [7:0] d;
        clk_evt = 4'b1001; step(); clk_evt = 4'b0000;
        step(3);
        rd(3'd4, 3'd0, d); check("R8 stop+lock", d, 8'h09);
        rd(3'd4, 3'd0, d); check("R8 cleared", d, 8'h00);
        clk_evt = 4'b0100; step(); clk_evt = 4'b0000;
        rd(3'd4, 3'd0, d); check("R8 unlock", d, 8'h04);
    endtask

    task automatic t_bit_read();
        logic [7:0] d;
        clk_evt = 4'b1111; step(); clk_evt = 4'b0000;
        rd(3'd5, 3'd2, d); check("R9 bit2", d, 8'h01);
        rd(3'd5, 3'd2, d); check("R9 bit2 cleared", d, 8'h00);
        rd(3'd5, 3'd6, d); check("R9 index out of range", d, 8'h00);
        rd(3'd4, 3'd0, d); check("R9 others kept", d, 8'h0B);
    endtask

    task automatic t_clear_all();
        logic [7:0] d;
        ovld_cond = 3'b001;
        step(2);
        clk_evt = 4'b0010; step(); clk_evt = 4'b0000;
        clr_all = 1'b1; step(); clr_all = 1'b0;
        rd(3'd0, 3'd0, d); check("R10 overload", d, 8'h00);
        rd(3'd4, 3'd0, d); check("R10 clock", d, 8'h00);
        ovld_cond = 3'b000;
        step(2);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        clk_evt = 4'b0010; step();
        rd(3'd4, 3'd0, d);
        clk_evt = 4'b0000;
        check("R11 read pre-clear", d, 8'h02);
        rd(3'd4, 3'd0, d); check("R11 flag survived", d, 8'h02);
        clk_evt = 4'b0100; clr_all = 1'b1; step();
        clk_evt = 4'b0000; clr_all = 1'b0;
        rd(3'd4, 3'd0, d); check("R11 clear vs event", d, 8'h04);
        ovld_cond = 3'b001;
        step(1);
        rd(3'd0, 3'd0, d); check("R11 overload pre-clear", d, 8'h00);
        rd(3'd0, 3'd0, d); check("R11 overload survived", d, 8'h01);
        ovld_cond = 3'b000;
        step(2);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        clk_evt = 4'b1000; step(); clk_evt = 4'b0000;
        cmd(3'd6, 3'd0, 8'hFF);
        check("R12 op6 no resp", {7'd0, rd_valid}, 8'h00);
        cmd(3'd7, 3'd3, 8'hFF);
        check("R12 op7 no resp", {7'd0, rd_valid}, 8'h00);
        rd(3'd4, 3'd0, d); check("R12 clock kept", d, 8'h08);
        rd(3'd3, 3'd0, d); check("R12 enable kept", d, 8'h00);
    endtask

    initial begin
        rst_n     = 1'b0;
        ovld_cond = '0;
        clk_evt   = '0;
        clr_all   = 1'b0;
        cmd_valid = 1'b0;
        cmd_op    = '0;
        cmd_idx   = '0;
        cmd_wdata = '0;
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_ovld_basic();
        t_persist();
        t_live();
        t_enable();
        t_clk_events();
        t_bit_read();
        t_clear_all();
        t_collision();
        t_reserved();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule